// File: doc/BRIEF.md
# Bus Cycle Hang Watchdog

This block guards a parallel backplane bus against cycles that never finish. When this node is the system controller, it starts timing as soon as either of the two data strobes is seen asserted. It counts microsecond ticks for as long as a strobe stays up. If the chosen limit is reached before both strobes have gone away, it raises a bus error. The error stays up until the strobes drop, and then it clears. Driving the error onto the bus wiring is handled outside the block.

The limit comes from a 2-bit select input. Three of its values give limits of 8, 64 and 256 ticks, and the fourth value switches the watchdog off. The select and the system-controller flag are captured once, at the start of each bus cycle. A change to either of them during a cycle therefore takes effect at the next strobe assertion. Both strobes are asynchronous to the local clock, so each one passes through a two-flop synchronizer before edge detection.

Top module: `bus_hang_watchdog`

## Requirements
- R1: While reset is held low and after reset is released, with no strobe asserted, `bus_err_o` is low.
- R2: A bus cycle begins when either strobe bit alone, or both together, becomes asserted (active high). Strobe bit 0 and strobe bit 1 each start timing on their own.
- R3: With select value 0 the limit is 8 ticks. `bus_err_o` is low after the 7th tick of a cycle and high after the 8th.
- R4: With select value 1 the limit is 64 ticks, and with select value 2 it is 256 ticks. The error is low after limit-1 ticks and high after the limit-th tick.
- R5: With select value 3 no error is ever raised, however many ticks pass.
- R6: When the system-controller flag is low at the start of a cycle, no error is raised in that cycle.
- R7: Once raised, `bus_err_o` stays high while at least one strobe is asserted, including when one strobe hands over to the other. It drops once both strobes are released.
- R8: The tick count restarts from zero at each new cycle. Ticks from an earlier cycle never add to a later one.
- R9: The select value and the system-controller flag are sampled when the cycle starts. Changing either of them mid-cycle does not alter the outcome of that cycle.
- R10: `bus_err_o` rises on the clock edge that samples the expiring tick. It falls on the third clock edge after both strobes are released: two edges for the synchronizer and one for the error register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| strobe_i | input | NUM_STROBES (2) | Data strobe activity, one bit per strobe, active high, asynchronous |
| sys_ctrl_i | input | 1 | High when this node is the system controller |
| tmo_sel_i | input | 2 | Limit select: 0=8, 1=64, 2=256 ticks, 3=off |
| tick_us_i | input | 1 | One-clock pulse per microsecond |
| bus_err_o | output | 1 | Bus error level, held until both strobes drop |

## Verification
The bench tests the off-by-one boundary of each limit: limit-1 ticks and limit ticks must give different results. An expiry that fired one tick early or one tick late would fail here. It also moves the select and the controller flag in mid-cycle, which catches a design that reads them live instead of latching them at the start of the cycle. It hands over from one strobe to the other while an error is up, and it runs back-to-back cycles that leave a partial count behind. A design that dropped the error at the first strobe change, or that carried a stale count into the next cycle, would fail these checks. Finally, the bench samples both sides of the expiring tick and counts the edges after strobe release, which pins the synchronizer depth.

// File: rtl/bhw_pkg.sv
// Package: shared encodings for the bus cycle hang watchdog.
// Assumes a 2-bit limit select whose top value disables the watchdog.
package bhw_pkg;

    typedef enum logic [1:0] {
        TMO_SHORT = 2'd0,
        TMO_MID   = 2'd1,
        TMO_LONG  = 2'd2,
        TMO_OFF   = 2'd3
    } tmo_sel_e;

    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/bhw_sync.sv
// Module: bhw_sync
// Carries one asynchronous level into the clock domain through a chain of
// flops. Assumes the input is a slow level, not a pulse shorter than a clock.
module bhw_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the input level along the flop chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/bhw_limit_decode.sv
// Module: bhw_limit_decode
// Turns the 2-bit select into a tick limit and an enable. Assumes each limit
// parameter is at least 1 and fits in CNT_W bits.
module bhw_limit_decode
    import bhw_pkg::*;
#(
    parameter int unsigned LIM_SHORT = 8,
    parameter int unsigned LIM_MID   = 64,
    parameter int unsigned LIM_LONG  = 256,
    parameter int unsigned CNT_W     = 9
) (
    input  logic [1:0]       sel_i,
    output logic [CNT_W-1:0] limit_o,
    output logic             en_o
);

    localparam logic [CNT_W-1:0] L_SHORT = CNT_W'(LIM_SHORT);
    localparam logic [CNT_W-1:0] L_MID   = CNT_W'(LIM_MID);
    localparam logic [CNT_W-1:0] L_LONG  = CNT_W'(LIM_LONG);

    // Map the select code onto a limit and an enable.
    always_comb begin
        unique case (tmo_sel_e'(sel_i))
            TMO_SHORT: begin limit_o = L_SHORT; en_o = 1'b1; end
            TMO_MID:   begin limit_o = L_MID;   en_o = 1'b1; end
            TMO_LONG:  begin limit_o = L_LONG;  en_o = 1'b1; end
            default:   begin limit_o = L_SHORT; en_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/bhw_timer.sv
// Module: bhw_timer
// Per-cycle tick counter and error flag. It latches the enable and the limit
// on the start pulse, counts ticks while the cycle lasts, and sets the error
// when the limit is reached. Everything clears when the cycle ends.
// Assumes start_i is only high in the first clock of active_i.
module bhw_timer #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             active_i,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic             arm_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             armed_o,
    output logic             err_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] limit_o
);

    logic             armed_q;
    logic             err_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] limit_q;
    logic             last_tick;

    assign last_tick = (count_q == limit_q - CNT_W'(1));

    // Track the cycle: capture on start, count ticks, set error at the limit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            armed_q <= 1'b0;
            err_q   <= 1'b0;
            count_q <= '0;
            limit_q <= '0;
        end else if (!active_i) begin
            armed_q <= 1'b0;
            err_q   <= 1'b0;
            count_q <= '0;
        end else if (start_i) begin
            armed_q <= arm_i;
            err_q   <= 1'b0;
            count_q <= '0;
            limit_q <= limit_i;
        end else if (armed_q && !err_q && tick_i) begin
            if (last_tick) begin
                err_q <= 1'b1;
            end else begin
                count_q <= count_q + CNT_W'(1);
            end
        end
    end

    assign armed_o = armed_q;
    assign err_o   = err_q;
    assign count_o = count_q;
    assign limit_o = limit_q;

endmodule

// File: rtl/bus_hang_watchdog.sv
// Module: bus_hang_watchdog
// Watches the data strobes of a backplane bus and raises a bus error when a
// cycle outlasts the selected limit. Active only while this node is system
// controller. Assumes the tick input is a single-clock pulse per microsecond.
module bus_hang_watchdog
    import bhw_pkg::*;
#(
    parameter int unsigned NUM_STROBES = 2,
    parameter int unsigned LIM_SHORT   = 8,
    parameter int unsigned LIM_MID     = 64,
    parameter int unsigned LIM_LONG    = 256
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NUM_STROBES-1:0] strobe_i,
    input  logic                   sys_ctrl_i,
    input  logic [1:0]             tmo_sel_i,
    input  logic                   tick_us_i,
    output logic                   bus_err_o
);

    localparam int unsigned LIM_MAX = (LIM_LONG > LIM_MID)
                                    ? ((LIM_LONG > LIM_SHORT) ? LIM_LONG : LIM_SHORT)
                                    : ((LIM_MID > LIM_SHORT) ? LIM_MID : LIM_SHORT);
    localparam int unsigned CNT_W = $clog2(LIM_MAX + 1);

    logic [NUM_STROBES-1:0] strobe_s;
    logic                   any_s;
    logic                   any_d;
    logic                   start;
    logic [CNT_W-1:0]       sel_limit;
    logic                   sel_en;
    logic                   armed;
    logic [CNT_W-1:0]       count;
    logic [CNT_W-1:0]       limit_q;
    logic                   err;

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_sync
        bhw_sync #(
            .STAGES(SYNC_STAGES)
        ) u_sync (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .d_i   (strobe_i[g]),
            .q_o   (strobe_s[g])
        );
    end

    assign any_s = |strobe_s;

    // Remember the previous synchronized activity for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            any_d <= 1'b0;
        end else begin
            any_d <= any_s;
        end
    end

    assign start = any_s & ~any_d;

    bhw_limit_decode #(
        .LIM_SHORT(LIM_SHORT),
        .LIM_MID  (LIM_MID),
        .LIM_LONG (LIM_LONG),
        .CNT_W    (CNT_W)
    ) u_decode (
        .sel_i  (tmo_sel_i),
        .limit_o(sel_limit),
        .en_o   (sel_en)
    );

    bhw_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .active_i(any_s),
        .start_i (start),
        .tick_i  (tick_us_i),
        .arm_i   (sel_en & sys_ctrl_i),
        .limit_i (sel_limit),
        .armed_o (armed),
        .err_o   (err),
        .count_o (count),
        .limit_o (limit_q)
    );

    assign bus_err_o = err;

endmodule

// File: rtl/bus_hang_watchdog_chk.sv
// Module: bus_hang_watchdog_chk
// Property checker bound to the watchdog top. It observes ports and internal
// state only and drives nothing.
module bus_hang_watchdog_chk #(
    parameter int unsigned CNT_W = 9
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             any_s,
    input logic             start,
    input logic             tick_us_i,
    input logic             sys_ctrl_i,
    input logic [1:0]       tmo_sel_i,
    input logic             armed,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] limit_q,
    input logic             bus_err_o
);

    // R1 / R7: the error clears on the edge after activity is gone
    p_err_clears_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !any_s |=> !bus_err_o);

    // R7: the error holds while any strobe remains active
    p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_err_o && any_s) |=> bus_err_o);

    // R5 / R6: an off select or a non-controller start leaves the timer disarmed
    p_disarmed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start && (tmo_sel_i == 2'd3 || !sys_ctrl_i)) |=> !armed);

    // R6: an error needs an armed cycle
    p_err_needs_arm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_err_o |-> armed);

    // R10: the error rises only on an edge that sampled a tick
    p_rise_on_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_err_o && !start && any_s && !tick_us_i) |=> !bus_err_o);

    // R8: the count is zero after an idle clock
    p_count_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !any_s |=> (count == '0));

    // R9: the latched limit holds for the rest of the cycle
    p_limit_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (any_s && !start) |=> $stable(limit_q));

    // R9: the armed state holds for the rest of the cycle
    p_arm_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (any_s && !start) |=> $stable(armed));

endmodule

bind bus_hang_watchdog bus_hang_watchdog_chk #(
    .CNT_W(CNT_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .any_s     (any_s),
    .start     (start),
    .tick_us_i (tick_us_i),
    .sys_ctrl_i(sys_ctrl_i),
    .tmo_sel_i (tmo_sel_i),
    .armed     (armed),
    .count     (count),
    .limit_q   (limit_q),
    .bus_err_o (bus_err_o)
);

// File: tb/bus_hang_watchdog_tb.sv
// Bench for the bus cycle hang watchdog: a vector table walked by one loop,
// then directed tests for reset, hold, restart, latching and latency.
module bus_hang_watchdog_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strobe = 2'b00;
    logic       sys_ctrl = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       tick = 1'b0;
    logic       err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bus_hang_watchdog u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .strobe_i  (strobe),
        .sys_ctrl_i(sys_ctrl),
        .tmo_sel_i (sel),
        .tick_us_i (tick),
        .bus_err_o (err)
    );

    // Vector fields: {strobe[1:0], sys_ctrl, sel[1:0], ticks[9:0], expected}
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {2'b01, 1'b1, 2'd0, 10'd7,   1'b0},
        {2'b01, 1'b1, 2'd0, 10'd8,   1'b1},
        {2'b10, 1'b1, 2'd0, 10'd8,   1'b1},
        {2'b11, 1'b1, 2'd0, 10'd8,   1'b1},
        {2'b01, 1'b1, 2'd1, 10'd63,  1'b0},
        {2'b01, 1'b1, 2'd1, 10'd64,  1'b1},
        {2'b10, 1'b1, 2'd2, 10'd255, 1'b0},
        {2'b10, 1'b1, 2'd2, 10'd256, 1'b1},
        {2'b01, 1'b1, 2'd3, 10'd300, 1'b0},
        {2'b01, 1'b0, 2'd0, 10'd300, 1'b0},
        {2'b01, 1'b0, 2'd2, 10'd300, 1'b0},
        {2'b11, 1'b1, 2'd3, 10'd10,  1'b0}
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: bus_err=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_cycle(input logic [1:0] s);
        @(negedge clk) strobe = s;
        idle(4);
    endtask

    task automatic end_cycle();
        @(negedge clk) strobe = 2'b00;
        idle(4);
    endtask

    function automatic string vec_tag(input logic sc, input logic [1:0] c);
        if (!sc)           return "R6";
        else if (c == 2'd3) return "R5";
        else if (c == 2'd0) return "R3";
        else               return "R4";
    endfunction

    // Watchdog: end a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, elapsed=1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle(3);
        check("R1 in reset", err, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        check("R1 after reset", err, 1'b0);

        // Vector table: R2..R6
        for (int v = 0; v < NV; v++) begin
            sys_ctrl = VEC[v][13];
            sel      = VEC[v][12:11];
            begin_cycle(VEC[v][15:14]);
            give_ticks(int'(VEC[v][10:1]));
            idle(1);
            check(vec_tag(VEC[v][13], VEC[v][12:11]), err, VEC[v][0]);
            end_cycle();
            check("R7 clear after vector", err, 1'b0);
        end

        // R2: each strobe bit alone starts timing
        sys_ctrl = 1'b1; sel = 2'd0;
        begin_cycle(2'b10);
        give_ticks(8);
        check("R2 strobe bit1 alone", err, 1'b1);
        end_cycle();

        // R7: hold through extra ticks and a strobe handover, then drop
        begin_cycle(2'b01);
        give_ticks(8);
        give_ticks(20);
        check("R7 hold extra ticks", err, 1'b1);
        @(negedge clk) strobe = 2'b10;
        idle(4);
        check("R7 hold across handover", err, 1'b1);
        end_cycle();
        check("R7 drop after release", err, 1'b0);

        // R8: count restarts for every cycle
        begin_cycle(2'b01);
        give_ticks(7);
        end_cycle();
        begin_cycle(2'b01);
        give_ticks(7);
        check("R8 no carry-over", err, 1'b0);
        give_ticks(1);
        check("R8 fresh limit", err, 1'b1);
        end_cycle();

        // R9: mid-cycle changes ignored
        sel = 2'd0;
        begin_cycle(2'b01);
        sel = 2'd3;
        give_ticks(8);
        check("R9 off select mid-cycle", err, 1'b1);
        end_cycle();
        begin_cycle(2'b01);
        sel = 2'd0;
        give_ticks(20);
        check("R9 on select mid-cycle", err, 1'b0);
        end_cycle();
        sel = 2'd0; sys_ctrl = 1'b1;
        begin_cycle(2'b01);
        sys_ctrl = 1'b0;
        give_ticks(8);
        check("R9 controller drop mid-cycle", err, 1'b1);
        end_cycle();
        sys_ctrl = 1'b0;
        begin_cycle(2'b01);
        sys_ctrl = 1'b1;
        give_ticks(20);
        check("R9 controller rise mid-cycle", err, 1'b0);
        end_cycle();

        // R10: latency at expiry and at release
        sys_ctrl = 1'b1; sel = 2'd0;
        begin_cycle(2'b11);
        give_ticks(7);
        @(negedge clk) tick = 1'b1;
        #1 check("R10 before expiring edge", err, 1'b0);
        @(negedge clk) tick = 1'b0;
        check("R10 after expiring edge", err, 1'b1);
        strobe = 2'b00;
        idle(2);
        check("R10 still high two edges after release", err, 1'b1);
        idle(1);
        check("R10 low three edges after release", err, 1'b0);
        idle(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule